// File: doc/BRIEF.md
# Message Buffer Arbitration and Match Scanner

This block owns a small array of message buffers and walks them in a single sequential pass, one buffer per clock in ascending index order. In a transmit round it selects the transmit-ready buffer with the smallest identifier. In a receive round it selects the first empty receive buffer whose identifier equals that of an incoming frame. If no such buffer is found, it reports that the frame was lost.

A CPU writes a buffer's control/status word (code plus identifier) through a register-style port. Any such write made while a round is running removes that buffer from the current round only. The scan never goes back to buffers it has already passed. A buffer that was the best candidate but is hit by a write therefore loses its place, and the search continues among the buffers that follow it. A freeze request is acknowledged only once no round is in progress. While the freeze is acknowledged, no new round can start.

Top module: `mb_scan_engine`

## Requirements
- R1: After reset, busy, res_done, res_valid, res_lost and frz_ack are all 0, and every buffer holds code 0 (inactive).
- R2: A start pulse accepted at a clock edge raises busy from that edge. The scan covers buffer 0 up to NUM_MB-1, one per clock. res_done is high for exactly one cycle, and it rises on the NUM_MB-th edge after the start edge, which is also the edge where busy falls. If start_tx and start_rx are both high, the round is a transmit round.
- R3: A transmit round reports, with res_valid=1, the index of the buffer with code 4'b1000 and the smallest identifier. On equal identifiers the lower index wins. If there is no candidate, res_valid=0 and res_lost=0.
- R4: A receive round compares against rx_frame_id as sampled at the start edge. It reports the lowest-index buffer with code 4'b0100 and that identifier, with res_valid=1 and res_lost=0. If none is found, res_valid=0 and res_lost=1. res_lost is never 1 after a transmit round.
- R5: A CPU write to buffer i while busy is high excludes buffer i from the current round. This includes a write in the same cycle that buffer i is scanned. A write in the cycle where the start is accepted does not exclude the buffer.
- R6: Exclusions last for one round only. The next round considers the buffer again with its stored contents.
- R7: If the current transmit best candidate is written after it was scanned, the winner is chosen only among the buffers scanned after that write. This holds even when an earlier buffer has a smaller identifier.
- R8: If the receive buffer that matched is written after it was scanned, only buffers scanned later can take the frame. If none does, res_lost=1, even when an earlier-scanned buffer also matched.
- R9: frz_ack rises on the first edge at which frz_req is high and no round is in progress or continuing. During a round this is the round's last edge. frz_ack stays high while frz_req is high and falls on the edge after frz_req drops.
- R10: A start pulse has no effect while busy or frz_ack is high. The running round's timing and result are unchanged, and no extra res_done appears.
- R11: CPU writes outside rounds update the stored code and identifier. Codes other than 4'b1000 and 4'b0100 are never selected, whatever their identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe to a control/status word |
| cpu_wr_idx | input | IDX_W | Buffer index written |
| cpu_wr_code | input | 4 | New buffer code |
| cpu_wr_id | input | ID_W | New buffer identifier |
| start_tx | input | 1 | Start a transmit arbitration round |
| start_rx | input | 1 | Start a receive match round |
| rx_frame_id | input | ID_W | Identifier of the received frame |
| frz_req | input | 1 | Freeze request |
| frz_ack | output | 1 | Freeze acknowledge |
| busy | output | 1 | Round in progress |
| res_done | output | 1 | One-cycle result strobe |
| res_idx | output | IDX_W | Selected buffer index |
| res_valid | output | 1 | A buffer was selected |
| res_lost | output | 1 | Receive frame found no buffer |

## Verification
The bench builds the block with its defaults: 16 buffers and 11-bit identifiers. Random identifiers are drawn from only eight values, so ties and multiple receive matches are common. With 16 scan slots per round, writes can be placed before, on and after the scan position of the current best candidate. This exercises every ordering of write against scan that R5, R7 and R8 distinguish. Freeze requests placed both in idle and mid-round cover the acknowledge timing against the round's last edge.

// File: rtl/mb_scan_pkg.sv
`timescale 1ns/1ps
package mb_scan_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_OFF      = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_TX_READY = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_RX_EMPTY = 4'b0100;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_state_e;

  // Transmit: candidate replaces the held best only on a strictly smaller id,
  // so the lower index keeps an equal id.
  function automatic logic tx_beats(input logic [CODE_W-1:0] code,
                                    input logic [31:0] cand_id,
                                    input logic best_vld,
                                    input logic [31:0] best_id);
    return (code == CODE_TX_READY) && (!best_vld || (cand_id < best_id));
  endfunction

  // Receive: an empty receive buffer with an equal identifier.
  function automatic logic rx_hits(input logic [CODE_W-1:0] code,
                                   input logic [31:0] cand_id,
                                   input logic [31:0] frame_id);
    return (code == CODE_RX_EMPTY) && (cand_id == frame_id);
  endfunction
endpackage

// File: rtl/mb_buf_array.sv
`timescale 1ns/1ps
module mb_buf_array
  import mb_scan_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [ID_W-1:0]   rd_id
);
  logic [CODE_W-1:0] code_q [NUM_MB];
  logic [ID_W-1:0]   id_q   [NUM_MB];
  logic [NUM_MB-1:0] wr_sel;

  for (genvar gi = 0; gi < NUM_MB; gi++) begin : g_sel
    assign wr_sel[gi] = wr_en && (wr_idx == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MB; i++) begin
        code_q[i] <= CODE_OFF;
        id_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (wr_sel[i]) begin
          code_q[i] <= wr_code;
          id_q[i]   <= wr_id;
        end
      end
    end
  end

  assign rd_code = code_q[rd_idx];
  assign rd_id   = id_q[rd_idx];
endmodule

// File: rtl/mb_deact_track.sv
`timescale 1ns/1ps
module mb_deact_track #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             round_start,
  input  logic             busy,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] scan_idx,
  input  logic [IDX_W-1:0] best_idx,
  input  logic             best_vld,
  output logic             cand_excl,
  output logic             best_kill
);
  logic [NUM_MB-1:0] deact_q;
  logic              live_wr;

  assign live_wr = busy && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           deact_q <= '0;
    else if (round_start) deact_q <= '0;
    else if (live_wr)     deact_q[wr_idx] <= 1'b1;
  end

  // A write in the same cycle counts as landing before the scan.
  assign cand_excl = deact_q[scan_idx] || (live_wr && (wr_idx == scan_idx));
  assign best_kill = live_wr && best_vld && (wr_idx == best_idx);
endmodule

// File: rtl/mb_round_ctrl.sv
`timescale 1ns/1ps
module mb_round_ctrl
  import mb_scan_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_tx,
  input  logic             start_rx,
  input  logic             frz_req,
  output logic             busy,
  output logic             is_tx,
  output logic [IDX_W-1:0] scan_idx,
  output logic             round_start,
  output logic             scan_last,
  output logic             frz_ack
);
  scan_state_e state_q;
  logic        ack_d;

  assign busy        = (state_q == ST_SCAN);
  assign round_start = !busy && !frz_ack && (start_tx || start_rx);
  assign scan_last   = busy && (scan_idx == IDX_W'(NUM_MB - 1));
  assign ack_d       = frz_req && !round_start && (!busy || scan_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      scan_idx <= '0;
      is_tx    <= 1'b0;
      frz_ack  <= 1'b0;
    end else begin
      frz_ack <= ack_d;
      if (round_start) begin
        state_q  <= ST_SCAN;
        scan_idx <= '0;
        is_tx    <= start_tx;
      end else if (scan_last) begin
        state_q  <= ST_IDLE;
        scan_idx <= '0;
      end else if (busy) begin
        scan_idx <= scan_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mb_pick_unit.sv
`timescale 1ns/1ps
module mb_pick_unit
  import mb_scan_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              round_start,
  input  logic              busy,
  input  logic              is_tx,
  input  logic [IDX_W-1:0]  scan_idx,
  input  logic              scan_last,
  input  logic [CODE_W-1:0] cand_code,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [ID_W-1:0]   frame_id_in,
  input  logic              cand_excl,
  input  logic              best_kill,
  output logic [IDX_W-1:0]  best_idx,
  output logic              best_vld,
  output logic              cand_take,
  output logic [IDX_W-1:0]  res_idx,
  output logic              res_valid,
  output logic              res_lost,
  output logic              res_done
);
  logic [ID_W-1:0]  best_id;
  logic [ID_W-1:0]  frame_id_q;
  logic             keep_vld;
  logic             nxt_vld;
  logic [IDX_W-1:0] nxt_idx;
  logic [ID_W-1:0]  nxt_id;

  always_comb begin
    keep_vld  = best_vld && !best_kill;
    if (is_tx)
      cand_take = !cand_excl && tx_beats(cand_code, 32'(cand_id), keep_vld, 32'(best_id));
    else
      cand_take = !cand_excl && !keep_vld && rx_hits(cand_code, 32'(cand_id), 32'(frame_id_q));
    nxt_vld = keep_vld || cand_take;
    nxt_idx = cand_take ? scan_idx : best_idx;
    nxt_id  = cand_take ? cand_id  : best_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_vld   <= 1'b0;
      best_idx   <= '0;
      best_id    <= '0;
      frame_id_q <= '0;
      res_idx    <= '0;
      res_valid  <= 1'b0;
      res_lost   <= 1'b0;
      res_done   <= 1'b0;
    end else begin
      res_done <= 1'b0;
      if (round_start) begin
        best_vld   <= 1'b0;
        frame_id_q <= frame_id_in;
      end else if (busy) begin
        best_vld <= nxt_vld;
        best_idx <= nxt_idx;
        best_id  <= nxt_id;
        if (scan_last) begin
          res_done  <= 1'b1;
          res_valid <= nxt_vld;
          res_idx   <= nxt_idx;
          res_lost  <= !is_tx && !nxt_vld;
        end
      end
    end
  end
endmodule

// File: rtl/mb_scan_engine.sv
`timescale 1ns/1ps
module mb_scan_engine
  import mb_scan_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [IDX_W-1:0]  cpu_wr_idx,
  input  logic [CODE_W-1:0] cpu_wr_code,
  input  logic [ID_W-1:0]   cpu_wr_id,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [ID_W-1:0]   rx_frame_id,
  input  logic              frz_req,
  output logic              frz_ack,
  output logic              busy,
  output logic              res_done,
  output logic [IDX_W-1:0]  res_idx,
  output logic              res_valid,
  output logic              res_lost
);
  logic              is_tx;
  logic [IDX_W-1:0]  scan_idx;
  logic              round_start;
  logic              scan_last;
  logic [CODE_W-1:0] cand_code;
  logic [ID_W-1:0]   cand_id;
  logic              cand_excl;
  logic              best_kill;
  logic              cand_take;
  logic [IDX_W-1:0]  best_idx;
  logic              best_vld;

  mb_round_ctrl #(.NUM_MB(NUM_MB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
    .frz_req(frz_req), .busy(busy), .is_tx(is_tx), .scan_idx(scan_idx),
    .round_start(round_start), .scan_last(scan_last), .frz_ack(frz_ack)
  );

  mb_buf_array #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_bufs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .wr_idx(cpu_wr_idx),
    .wr_code(cpu_wr_code), .wr_id(cpu_wr_id), .rd_idx(scan_idx),
    .rd_code(cand_code), .rd_id(cand_id)
  );

  mb_deact_track #(.NUM_MB(NUM_MB)) u_deact (
    .clk(clk), .rst_n(rst_n), .round_start(round_start), .busy(busy),
    .wr_en(cpu_wr_en), .wr_idx(cpu_wr_idx), .scan_idx(scan_idx),
    .best_idx(best_idx), .best_vld(best_vld),
    .cand_excl(cand_excl), .best_kill(best_kill)
  );

  mb_pick_unit #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .round_start(round_start), .busy(busy),
    .is_tx(is_tx), .scan_idx(scan_idx), .scan_last(scan_last),
    .cand_code(cand_code), .cand_id(cand_id), .frame_id_in(rx_frame_id),
    .cand_excl(cand_excl), .best_kill(best_kill),
    .best_idx(best_idx), .best_vld(best_vld), .cand_take(cand_take),
    .res_idx(res_idx), .res_valid(res_valid), .res_lost(res_lost),
    .res_done(res_done)
  );
endmodule

// File: rtl/mb_scan_chk.sv
`timescale 1ns/1ps
module mb_scan_chk #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             scan_last,
  input logic [IDX_W-1:0] scan_idx,
  input logic             is_tx,
  input logic             cand_take,
  input logic             cpu_wr_en,
  input logic [IDX_W-1:0] cpu_wr_idx,
  input logic             start_tx,
  input logic             start_rx,
  input logic             frz_ack,
  input logic             res_done,
  input logic             res_valid,
  input logic             res_lost
);
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(scan_last)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done); // R2
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !scan_last |=> busy && (scan_idx == IDX_W'($past(scan_idx) + 1'b1))); // R2
  AST_LOST_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_lost |-> !res_valid); // R4
  AST_LOST_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_lost |-> !is_tx); // R4
  AST_WRITE_EXCLUDES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_wr_en && (cpu_wr_idx == scan_idx) |-> !cand_take); // R5
  AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frz_ack |-> !busy); // R9
  AST_FREEZE_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    frz_ack && (start_tx || start_rx) |=> !busy); // R10
endmodule

bind mb_scan_engine mb_scan_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .scan_last(scan_last),
  .scan_idx(scan_idx), .is_tx(is_tx), .cand_take(cand_take),
  .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx), .start_tx(start_tx),
  .start_rx(start_rx), .frz_ack(frz_ack), .res_done(res_done),
  .res_valid(res_valid), .res_lost(res_lost)
);

// File: tb/mb_scan_engine_tb_top.sv
`timescale 1ns/1ps
module mb_scan_engine_tb_top;
  localparam int N  = 16;
  localparam int IW = 11;
  localparam int XW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [XW-1:0] cpu_wr_idx = '0;
  logic [3:0] cpu_wr_code = '0;
  logic [IW-1:0] cpu_wr_id = '0;
  logic start_tx = 1'b0, start_rx = 1'b0;
  logic [IW-1:0] rx_frame_id = '0;
  logic frz_req = 1'b0;
  logic frz_ack, busy, res_done, res_valid, res_lost;
  logic [XW-1:0] res_idx;

  always #2.5 clk = ~clk;

  mb_scan_engine #(.NUM_MB(N), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx),
    .cpu_wr_code(cpu_wr_code), .cpu_wr_id(cpu_wr_id), .start_tx(start_tx),
    .start_rx(start_rx), .rx_frame_id(rx_frame_id), .frz_req(frz_req),
    .frz_ack(frz_ack), .busy(busy), .res_done(res_done), .res_idx(res_idx),
    .res_valid(res_valid), .res_lost(res_lost)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Bench model of buffer contents
  logic [3:0]    m_code [N];
  logic [IW-1:0] m_id   [N];
  // Per-scan-slot write schedule for the next round
  bit            s_wr [N];
  int            s_idx [N];
  logic [3:0]    s_code [N];
  logic [IW-1:0] s_id [N];
  bit            s_restart [N];
  bit            pre_wr;
  int            pre_idx;
  int            frz_at;
  bit            last_valid, last_lost;
  int            last_idx;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] rnd_code();
    case ($urandom % 4)
      0: return 4'b0000;
      1: return 4'b1000;
      2: return 4'b0100;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic clear_sched();
    for (int k = 0; k < N; k++) begin
      s_wr[k] = 0; s_restart[k] = 0; s_idx[k] = 0; s_code[k] = '0; s_id[k] = '0;
    end
    pre_wr = 0; pre_idx = 0; frz_at = -1;
  endtask

  task automatic cpu_write(input int idx, input logic [3:0] code, input logic [IW-1:0] id);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_idx = XW'(idx); cpu_wr_code = code; cpu_wr_id = id;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    m_code[idx] = code; m_id[idx] = id;
  endtask

  // Expected result from the requirements, one slot at a time.
  task automatic predict(input bit tx, input logic [IW-1:0] fid,
                         output bit ev, output int ei, output bit el);
    bit deact [N];
    bit bv = 0; int bi = 0; logic [IW-1:0] bid = '0;
    for (int k = 0; k < N; k++) deact[k] = 0;
    for (int k = 0; k < N; k++) begin
      if (s_wr[k]) begin
        deact[s_idx[k]] = 1;
        if (bv && bi == s_idx[k]) bv = 0;
      end
      if (!deact[k]) begin
        if (tx) begin
          if (m_code[k] == 4'b1000 && (!bv || m_id[k] < bid)) begin bv = 1; bi = k; bid = m_id[k]; end
        end else begin
          if (m_code[k] == 4'b0100 && m_id[k] == fid && !bv) begin bv = 1; bi = k; bid = m_id[k]; end
        end
      end
      if (s_wr[k]) begin m_code[s_idx[k]] = s_code[k]; m_id[s_idx[k]] = s_id[k]; end
    end
    ev = bv; ei = bi; el = !tx && !bv;
  endtask

  task automatic run_round(input bit tx, input logic [IW-1:0] fid, input string req);
    bit ev, el; int ei;
    if (pre_wr) begin m_code[pre_idx] = s_code[0] ^ 4'b0000; end
    predict(tx, fid, ev, ei, el);
    @(negedge clk);
    start_tx = tx; start_rx = !tx; rx_frame_id = fid;
    @(negedge clk);
    start_tx = 0; start_rx = 0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    for (int k = 0; k < N; k++) begin
      cpu_wr_en = s_wr[k]; cpu_wr_idx = XW'(s_idx[k]);
      cpu_wr_code = s_code[k]; cpu_wr_id = s_id[k];
      start_tx = s_restart[k]; start_rx = 1'b0;
      if (frz_at >= 0 && k >= frz_at) frz_req = 1'b1;
      if (frz_at >= 0 && k == N - 1) chk(frz_ack == 1'b0, "R9", "ack while busy", frz_ack, 0);
      if (k == N - 1) chk(res_done == 1'b0, "R2", "done early", res_done, 0);
      @(negedge clk);
    end
    cpu_wr_en = 0; start_tx = 0;
    chk(res_done == 1'b1, req, "done strobe", res_done, 1);
    chk(res_valid == ev, req, "valid", res_valid, ev);
    if (ev) chk(res_idx == XW'(ei), req, "index", res_idx, ei);
    chk(res_lost == el, req, "lost", res_lost, el);
    chk(busy == 1'b0, "R2", "busy after done", busy, 0);
    if (frz_at >= 0) chk(frz_ack == 1'b1, "R9", "ack at round end", frz_ack, 1);
    last_valid = res_valid; last_lost = res_lost; last_idx = res_idx;
    @(negedge clk);
    chk(res_done == 1'b0, "R2", "done one cycle", res_done, 0);
    if (frz_at >= 0) begin
      frz_req = 0;
      @(negedge clk);
      chk(frz_ack == 1'b0, "R9", "ack release", frz_ack, 0);
    end
    clear_sched();
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) cpu_write(i, 4'b0000, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1);
    for (int i = 0; i < N; i++) begin m_code[i] = '0; m_id[i] = '0; end
    clear_sched();
    repeat (3) @(negedge clk);
    chk(busy == 0 && res_done == 0 && frz_ack == 0, "R1", "idle after reset", busy, 0);
    chk(res_valid == 0 && res_lost == 0, "R1", "result after reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all buffers inactive -> tx round finds nothing
    run_round(1'b1, '0, "R1");
    chk(last_valid == 0, "R1", "no candidate after reset", last_valid, 0);

    // R3: tie on lowest id, lower index wins
    cpu_write(3, 4'b1000, 11'd5); cpu_write(9, 4'b1000, 11'd5); cpu_write(12, 4'b1000, 11'd40);
    run_round(1'b1, '0, "R3");
    chk(last_idx == 3, "R3", "tie picks lower index", last_idx, 3);

    // R11: other codes never chosen even with lowest id
    cpu_write(0, 4'b0010, 11'd0);
    run_round(1'b1, '0, "R11");
    chk(last_idx == 3, "R11", "unknown code skipped", last_idx, 3);

    // R7: best written after scanning, earlier smaller id not revisited
    clear_all();
    cpu_write(1, 4'b1000, 11'd7); cpu_write(2, 4'b1000, 11'd1); cpu_write(10, 4'b1000, 11'd9);
    s_wr[5] = 1; s_idx[5] = 2; s_code[5] = 4'b1000; s_id[5] = 11'd1;
    run_round(1'b1, '0, "R7");
    chk(last_valid && last_idx == 10, "R7", "winner from later buffers", last_idx, 10);
    // R6: exclusion gone next round
    run_round(1'b1, '0, "R6");
    chk(last_idx == 2, "R6", "buffer back next round", last_idx, 2);

    // R5: write in same cycle as scan excludes it
    s_wr[2] = 1; s_idx[2] = 2; s_code[2] = 4'b1000; s_id[2] = 11'd1;
    run_round(1'b1, '0, "R5");
    chk(last_idx == 1, "R5", "same-cycle write excludes", last_idx, 1);

    // R8: matched rx buffer written after scan, later match already passed -> lost
    clear_all();
    cpu_write(4, 4'b0100, 11'd33); cpu_write(6, 4'b0100, 11'd33);
    s_wr[8] = 1; s_idx[8] = 4; s_code[8] = 4'b0100; s_id[8] = 11'd33;
    run_round(1'b0, 11'd33, "R8");
    chk(last_lost == 1, "R8", "frame lost", last_lost, 1);
    // R4: plain rx match, first in order
    run_round(1'b0, 11'd33, "R4");
    chk(last_idx == 4 && !last_lost, "R4", "first match", last_idx, 4);
    run_round(1'b0, 11'd34, "R4");
    chk(last_lost == 1, "R4", "no match lost", last_lost, 1);

    // R10: restart mid-round ignored
    s_restart[7] = 1; s_restart[15] = 1;
    run_round(1'b0, 11'd33, "R10");
    repeat (3) @(negedge clk);
    chk(busy == 0 && res_done == 0, "R10", "no extra round", busy, 0);

    // R9/R10: idle freeze
    @(negedge clk); frz_req = 1;
    @(negedge clk);
    chk(frz_ack == 1, "R9", "idle ack", frz_ack, 1);
    start_tx = 1;
    @(negedge clk); start_tx = 0;
    chk(busy == 0, "R10", "start blocked by freeze", busy, 0);
    frz_req = 0;
    @(negedge clk);
    chk(frz_ack == 0, "R9", "ack drop", frz_ack, 0);

    // R9: freeze during round
    frz_at = 3;
    run_round(1'b0, 11'd33, "R9");

    // Random rounds
    for (int r = 0; r < 80; r++) begin
      if (r % 8 == 0)
        for (int i = 0; i < N; i++) cpu_write(i, rnd_code(), IW'($urandom % 8));
      for (int k = 0; k < N; k++) begin
        s_wr[k] = ($urandom % 6) == 0;
        s_idx[k] = $urandom % N;
        s_code[k] = rnd_code();
        s_id[k] = IW'($urandom % 8);
      end
      run_round(($urandom % 2) == 1, IW'($urandom % 8), (r % 2) ? "R7" : "R8");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule